// File: doc/BRIEF.md
# Serial Page-Program Buffer

This block sits behind a serial slave front end and handles one write command: a page-program frame. While chip select is low, bits arrive one per strobe, most significant bit first. The block packs them into bytes and decodes the command byte and three address bytes. Every data byte that follows goes into a 256-byte staging buffer. A column pointer starts at the low address byte and wraps inside the page.

When chip select is released, the block decides whether to commit. It commits only if the frame carried the program command and at least one whole data byte, the external write-enable latch is set, and the target page is not locked. On commit it raises `busy` for a fixed number of clocks. During that window it sweeps the staged columns into the array. Each staged byte is merged with AND, so programming can only clear bits. When `busy` drops, a one-cycle pulse tells the owner of the write-enable latch to clear it. A separate read port lets the rest of the chip, or a bench, inspect the array.

Top module: `flash_page_prog`

## Requirements
- R1: After reset `busy` and `wel_clr` are 0 and every array byte reads 8'hFF.
- R2: A frame is the command byte 8'h02, three address bytes (high, middle, low) and then data bytes. Every byte is sent most significant bit first, and a bit is taken on a clock where `cs_n` is 0 and `bit_stb` is 1. A frame whose command byte is anything else changes nothing and raises no `busy`.
- R3: The first data byte lands in the column given by the low address byte. Each following byte goes to the next column. The middle address byte's low ADDR_W-8 bits select the page.
- R4: After column 255 the pointer returns to column 0 of the same page. When more than 256 bytes arrive, each column keeps the last byte written to it.
- R5: Bits left over after the last whole byte when `cs_n` rises are discarded and write nothing.
- R6: Commit happens only on the release of `cs_n`, and only when `wel_in` is 1 at that moment. Otherwise the array is unchanged and `busy` stays 0.
- R7: A frame aimed at a page whose `page_lock` bit is 1 is ignored: no change and no `busy`.
- R8: Only columns that received a byte are written. Each written array byte becomes old AND new.
- R9: A commit raises `busy` within three clocks of `cs_n` rising. `busy` stays high for exactly PROG_CYC clocks. `wel_clr` pulses for one clock in the cycle `busy` falls.
- R10: A frame sent while `busy` is high is ignored. Its data does not reach the array, and it starts no further `busy` period.
- R11: Address bits above ADDR_W are ignored. A frame with no whole data byte commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select, synchronous to clk |
| bit_stb | input | 1 | Serial bit is valid this clock |
| bit_in | input | 1 | Serial data bit |
| wel_in | input | 1 | Write-enable latch state |
| page_lock | input | 2**(ADDR_W-8) | Per-page protection, 1 = locked |
| rd_addr | input | ADDR_W | Array read address |
| busy | output | 1 | Program interval in progress |
| wel_clr | output | 1 | One-clock request to clear write enable |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
The hardest case to reach from the ports is a complete, valid frame that arrives while a commit is still sweeping the buffer. The buffer must stay frozen, and no second `busy` may follow. The bench watches for `busy` to rise, then drives a whole enabled frame into another page inside the window. Afterwards it checks both the length of the window and that page's contents. Overrun past 256 bytes and a trailing partial byte are covered by frames of 300 bytes and of 5 bytes plus 3 stray bits. The results are compared against a byte-level model of the wrapped column pointer.

// File: rtl/fpp_pkg.sv
`timescale 1ns/1ps
package fpp_pkg;
  localparam int          PAGE_BYTES   = 256;
  localparam int          COL_W        = 8;
  localparam logic [7:0]  OP_PAGE_PROG = 8'h02;

  typedef enum logic [2:0] {
    PH_OPC  = 3'd0,
    PH_AHI  = 3'd1,
    PH_AMID = 3'd2,
    PH_ALO  = 3'd3,
    PH_DATA = 3'd4
  } phase_t;

  // column pointer advance, wraps inside the page
  function automatic logic [COL_W-1:0] col_advance(input logic [COL_W-1:0] c);
    return c + COL_W'(1);
  endfunction

  // programming can only clear bits
  function automatic logic [7:0] and_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction
endpackage

// File: rtl/fpp_shifter.sv
`timescale 1ns/1ps
module fpp_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       bit_stb,
  input  logic       bit_in,
  output logic       byte_stb,
  output logic [7:0] byte_val
);
  logic [2:0] bit_cnt;
  logic [6:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_stb <= 1'b0;
      byte_val <= '0;
    end else begin
      byte_stb <= 1'b0;
      if (cs_n) begin
        bit_cnt <= '0;             // partial byte dropped here
      end else if (bit_stb) begin
        shreg   <= {shreg[5:0], bit_in};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_stb <= 1'b1;
          byte_val <= {shreg, bit_in};
        end
      end
    end
  end

  a_r5_byte_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> $past(!cs_n && bit_stb));
endmodule

// File: rtl/fpp_frame.sv
`timescale 1ns/1ps
module fpp_frame
  import fpp_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int PAGE_W = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [7:0]        byte_val,
  input  logic              end_evt,
  input  logic              busy,
  input  logic [COL_W-1:0]  sweep_col,
  output logic [7:0]        buf_byte,
  output logic              buf_vld,
  output logic              frame_ready,
  output logic [PAGE_W-1:0] tgt_page,
  output logic              data_wr
);
  phase_t                  phase;
  logic                    op_ok;
  logic                    got_data;
  logic [COL_W-1:0]        col;
  logic [PAGE_W-1:0]       page_q;
  logic [PAGE_BYTES-1:0]   vld_bits;
  logic [7:0]              stage [PAGE_BYTES];
  logic                    op_accept;

  assign op_accept   = byte_stb && (phase == PH_OPC) && (byte_val == OP_PAGE_PROG) && !busy;
  assign data_wr     = byte_stb && (phase == PH_DATA) && op_ok;
  assign frame_ready = op_ok && (phase == PH_DATA) && got_data;
  assign tgt_page    = page_q;
  assign buf_byte    = stage[sweep_col];
  assign buf_vld     = vld_bits[sweep_col];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_OPC;
      op_ok    <= 1'b0;
      got_data <= 1'b0;
      col      <= '0;
      page_q   <= '0;
      vld_bits <= '0;
    end else if (end_evt) begin
      phase    <= PH_OPC;
      op_ok    <= 1'b0;
      got_data <= 1'b0;
    end else if (byte_stb) begin
      case (phase)
        PH_OPC: begin
          op_ok <= op_accept;
          if (op_accept) vld_bits <= '0;
          phase <= PH_AHI;
        end
        PH_AHI:  phase <= PH_AMID;   // bits above the array are dropped
        PH_AMID: begin
          page_q <= byte_val[PAGE_W-1:0];
          phase  <= PH_ALO;
        end
        PH_ALO: begin
          col   <= byte_val;
          phase <= PH_DATA;
        end
        PH_DATA: begin
          if (op_ok) begin
            vld_bits[col] <= 1'b1;
            col           <= col_advance(col);
            got_data      <= 1'b1;
          end
        end
        default: phase <= PH_OPC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (data_wr) stage[col] <= byte_val;
  end

  a_r4_col_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (col == $past(col) + 8'd1));
  a_r10_buf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(vld_bits));
endmodule

// File: rtl/fpp_seq.sv
`timescale 1ns/1ps
module fpp_seq
  import fpp_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PROG_CYC = 300,
  localparam int PAGE_W  = ADDR_W - COL_W,
  localparam int NPAGES  = 1 << PAGE_W,
  localparam int TMR_W   = $clog2(PROG_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wel_in,
  input  logic [NPAGES-1:0] page_lock,
  input  logic              frame_ready,
  input  logic [PAGE_W-1:0] tgt_page,
  input  logic              buf_vld,
  input  logic [7:0]        buf_byte,
  output logic              end_evt,
  output logic              commit_go,
  output logic              busy,
  output logic              wel_clr,
  output logic [COL_W-1:0]  sweep_col,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic              cs_q, cs_q2;
  logic [TMR_W-1:0]  tmr;
  logic [PAGE_W-1:0] page_q;
  logic              in_sweep;

  // release seen one clock late so the last byte is already staged
  assign end_evt   = cs_q && !cs_q2;
  assign commit_go = end_evt && !busy && frame_ready && wel_in && !page_lock[tgt_page];
  assign sweep_col = tmr[COL_W-1:0];
  assign in_sweep  = busy && (tmr < TMR_W'(PAGE_BYTES));
  assign wr_en     = in_sweep && buf_vld;
  assign wr_addr   = {page_q, sweep_col};
  assign wr_data   = buf_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      cs_q2   <= 1'b1;
      busy    <= 1'b0;
      wel_clr <= 1'b0;
      tmr     <= '0;
      page_q  <= '0;
    end else begin
      cs_q    <= cs_n;
      cs_q2   <= cs_q;
      wel_clr <= 1'b0;
      if (commit_go) begin
        busy   <= 1'b1;
        tmr    <= '0;
        page_q <= tgt_page;
      end else if (busy) begin
        tmr <= tmr + TMR_W'(1);
        if (tmr == TMR_W'(PROG_CYC - 1)) begin
          busy    <= 1'b0;
          wel_clr <= 1'b1;
        end
      end
    end
  end

  a_r9_busy_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_go));
  a_r9_welclr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> (!busy && $past(busy)));
  a_r6_go_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> (cs_n && $past(cs_n)));
endmodule

// File: rtl/fpp_array.sv
`timescale 1ns/1ps
module fpp_array
  import fpp_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [7:0] mem [DEPTH];

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wr_en) begin
      mem[wr_addr] <= and_merge(mem[wr_addr], wr_data);
    end
  end

  a_r8_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);
  a_r8_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_addr == wr_addr) |=> ((rd_data & ~$past(rd_data)) == 8'h00));
endmodule

// File: rtl/flash_page_prog.sv
`timescale 1ns/1ps
module flash_page_prog
  import fpp_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PROG_CYC = 300,
  localparam int PAGE_W  = ADDR_W - COL_W,
  localparam int NPAGES  = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              bit_stb,
  input  logic              bit_in,
  input  logic              wel_in,
  input  logic [NPAGES-1:0] page_lock,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              wel_clr,
  output logic [7:0]        rd_data
);
  logic              byte_stb;
  logic [7:0]        byte_val;
  logic              end_evt;
  logic              commit_go;
  logic [COL_W-1:0]  sweep_col;
  logic [7:0]        buf_byte;
  logic              buf_vld;
  logic              frame_ready;
  logic [PAGE_W-1:0] tgt_page;
  logic              data_wr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;

  fpp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_stb(bit_stb), .bit_in(bit_in),
    .byte_stb(byte_stb), .byte_val(byte_val)
  );

  fpp_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_val(byte_val),
    .end_evt(end_evt), .busy(busy), .sweep_col(sweep_col),
    .buf_byte(buf_byte), .buf_vld(buf_vld), .frame_ready(frame_ready),
    .tgt_page(tgt_page), .data_wr(data_wr)
  );

  fpp_seq #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wel_in(wel_in), .page_lock(page_lock),
    .frame_ready(frame_ready), .tgt_page(tgt_page), .buf_vld(buf_vld),
    .buf_byte(buf_byte), .end_evt(end_evt), .commit_go(commit_go), .busy(busy),
    .wel_clr(wel_clr), .sweep_col(sweep_col), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  fpp_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  a_r10_no_stage_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |-> !busy);
endmodule

// File: tb/flash_page_prog_test.sv
`timescale 1ns/1ps
module flash_page_prog_test;
  localparam int AW = 10;
  localparam int PC = 300;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          bit_stb = 1'b0;
  logic          bit_in = 1'b0;
  logic          wel_in = 1'b0;
  logic [NP-1:0] page_lock = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          busy;
  logic          wel_clr;
  logic [7:0]    rd_data;

  flash_page_prog #(.ADDR_W(AW), .PROG_CYC(PC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_stb(bit_stb), .bit_in(bit_in),
    .wel_in(wel_in), .page_lock(page_lock), .rd_addr(rd_addr),
    .busy(busy), .wel_clr(wel_clr), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int addr; logic [7:0] data; string req; } item_t;
  item_t      sb_q[$];
  logic [7:0] model [NP*256];
  int         tests = 0;
  int         fails = 0;
  bit         done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 53 + i * 29 + i / 7) ^ (s << 3));
  endfunction

  // monitor: pops expected bytes and compares against the read port
  initial begin
    item_t it;
    forever begin
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      @(negedge clk);
      rd_addr = AW'(it.addr);
      #1;
      chk(it.req, {24'd0, rd_data}, {24'd0, it.data});
    end
  end

  task automatic push_page(input int page, input string req);
    for (int c = 0; c < 256; c++) sb_q.push_back('{page * 256 + c, model[page * 256 + c], req});
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    cs_n = 1'b0; bit_stb = 1'b1; bit_in = b;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_frame(input logic [7:0] op, input int addr, input int n,
                            input int extra, input int seed);
    logic [7:0] tail;
    send_byte(op);
    send_byte(8'(addr >> 16));
    send_byte(8'(addr >> 8));
    send_byte(8'(addr));
    for (int i = 0; i < n; i++) send_byte(pat(seed, i));
    tail = pat(seed, n);
    for (int i = 0; i < extra; i++) send_bit(tail[7 - i]);
    @(negedge clk);
    bit_stb = 1'b0; cs_n = 1'b1;
  endtask

  // reference: expected commit decision and array update
  function automatic bit model_prog(input logic [7:0] op, input int addr, input int n,
                                    input int seed, input bit wel);
    logic [7:0] nb [256];
    bit         hit [256];
    int         page = (addr >> 8) % NP;
    int         col0 = addr & 255;
    if (op != 8'h02 || n < 1 || !wel || page_lock[page]) return 1'b0;
    for (int c = 0; c < 256; c++) hit[c] = 1'b0;
    for (int i = 0; i < n; i++) begin
      nb[(col0 + i) % 256]  = pat(seed, i);
      hit[(col0 + i) % 256] = 1'b1;
    end
    for (int c = 0; c < 256; c++)
      if (hit[c]) model[page * 256 + c] = model[page * 256 + c] & nb[c];
    return 1'b1;
  endfunction

  task automatic run(input logic [7:0] op, input int addr, input int n, input int extra,
                     input int seed, input bit wel, input string req, input bit overlap);
    bit go, seen, seen2;
    int rise;
    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
    wel_in = wel;
    send_frame(op, addr, n, extra, seed);
    go = model_prog(op, addr, n, seed, wel);
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (busy) begin seen = 1'b1; break; end
    end
    chk({req, " busy start"}, 32'(seen), 32'(go));
    if (seen) begin
      rise = cyc;
      if (overlap) send_frame(8'h02, 32'h000300, 4, 0, 77); // R10: must be ignored
      while (busy) @(negedge clk);
      chk("R9 busy length", 32'(cyc - rise), 32'(PC));
      chk("R9 wel_clr at busy end", 32'(wel_clr), 32'd1);
      @(negedge clk);
      chk("R9 wel_clr single pulse", 32'(wel_clr), 32'd0);
      seen2 = 1'b0;
      repeat (8) begin @(negedge clk); if (busy) seen2 = 1'b1; end
      chk(overlap ? "R10 no second busy" : "R9 no extra busy", 32'(seen2), 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < NP * 256; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 wel_clr after reset", 32'(wel_clr), 32'd0);
    push_page(0, "R1 erased array");

    run(8'h02, 32'h000000, 256, 0, 1, 1'b1, "R2 R3 full page", 1'b0);
    push_page(0, "R3 full page data");
    run(8'h02, 32'h0001F0, 40, 0, 2, 1'b1, "R4 wrap", 1'b0);
    push_page(1, "R4 wrap to column 0");
    run(8'h02, 32'h000210, 300, 0, 3, 1'b1, "R4 overrun", 1'b0);
    push_page(2, "R4 last 256 kept");
    run(8'h02, 32'h000320, 5, 3, 4, 1'b1, "R5 partial", 1'b0);
    push_page(3, "R5 partial byte dropped");
    run(8'h02, 32'h000340, 8, 0, 5, 1'b0, "R6 no write enable", 1'b0);
    push_page(3, "R6 unchanged");
    page_lock = 4'b0010;
    run(8'h02, 32'h000100, 16, 0, 6, 1'b1, "R7 locked", 1'b0);
    push_page(1, "R7 locked page unchanged");
    page_lock = 4'b0000;
    run(8'h03, 32'h000000, 16, 0, 7, 1'b1, "R2 other opcode", 1'b0);
    push_page(0, "R2 other opcode unchanged");
    run(8'h02, 32'h000080, 64, 0, 9, 1'b1, "R8 reprogram", 1'b0);
    push_page(0, "R8 AND merge");
    run(8'h02, 32'hFC0230, 10, 0, 11, 1'b1, "R11 high address", 1'b0);
    push_page(2, "R11 high bits ignored");
    run(8'h02, 32'h000300, 0, 0, 12, 1'b1, "R11 no data", 1'b0);
    push_page(3, "R11 empty frame");
    run(8'h02, 32'h000100, 20, 0, 13, 1'b1, "R10 overlap", 1'b1);
    push_page(1, "R10 first frame written");
    push_page(3, "R10 second frame ignored");

    wait (sb_q.size() == 0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule